// File: doc/BRIEF.md
# Dual-Channel Serial Register Bank with Broadcast Write

This block is the host-side register front-end of a two-channel serial controller. A host reaches it over an 8-bit parallel bus: a 3-bit address, write data, a read strobe, a write strobe and a channel-select bit (0 = channel A, 1 = channel B). Each channel keeps a scratch byte, a 16-bit baud divisor held as low and high bytes, a divisor-enable bit, and the mode fields of an alternate function register. A shared broadcast flag lets one host write land in both channels. This halves the time needed to bring two channels up to the same setup.

Each channel drives an active-low multifunction pin. A two-bit field picks its source: the modem output-2 control, the channel's baud clock, a fixed inactive level, or receive-ready. The transmitter, receiver, FIFOs, interrupts and modem logic sit outside this block. The output-2 and receive-ready levels arrive as plain active-high inputs.

The baud generator divides the input clock by the 16-bit divisor. This gives the 16x sample clock, so the bit rate is the clock divided by 16 and then by the divisor.

Top module: `dual_reg_bank`

## Requirements
- R1: After reset both scratch bytes read 0xFF. Divisor bytes, divisor-enable, mode select and the broadcast flag are all 0, and each pin drives the inverse of its output-2 input.
- R2: With the broadcast flag at 0, a write changes only the channel named by the channel-select input.
- R3: With the broadcast flag at 1, one write updates the addressed register in both channels.
- R4: The broadcast flag is bit 0 of the alternate function register. It can be set or cleared through either channel, and it reads back identically through both.
- R5: A read returns data from the channel named by the channel-select input, even while broadcast is on. With the read strobe low, the read data is 0.
- R6: Bits 7:3 of the alternate function register always read 0, whatever is written to them.
- R7: Address 7 is a scratch byte that reads back what was last written to it.
- R8: Address 3 holds the divisor-enable bit in bit 7 (other bits read 0). When a channel's enable is 1, addresses 0, 1 and 2 reach that channel's divisor low byte, divisor high byte and alternate function register. When it is 0, writes there do nothing and reads return 0. During a broadcast write, each channel decodes these addresses using its own enable bit.
- R9: Alternate function bits 2:1 pick the pin source. 00 drives the inverted output-2 input, 01 the active-low baud clock, 10 a constant 1, and 11 the inverted receive-ready input.
- R10: The baud clock is a one-cycle low pulse every D clocks, where D = {high byte, low byte}. A divisor of 0 acts as 1.
- R11: Writes take effect on the clock edge that samples the write strobe. Read data follows the address and channel select combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, active high |
| bus_rd | input | 1 | Read strobe, active high |
| chan_sel | input | 1 | Channel select, 0 = A, 1 = B |
| bus_rdata | output | 8 | Read data |
| op2_in | input | 2 | Per-channel output-2 control level, active high |
| rx_ready_in | input | 2 | Per-channel receive-ready level, active high |
| mf_n | output | 2 | Per-channel multifunction pins, active low |

## Verification
The hardest state to reach is a broadcast write that lands while the two channels disagree on their divisor-enable bits. One channel then stores into its divisor or mode register, while the other treats the same address as out of scope. Random stimulus writes the line-control address with random data, so each enable bit flips often and on its own. Random writes to address 2 toggle the broadcast flag, and a directed case sets up the split-enable broadcast on purpose and then reads both channels back.

// File: rtl/drb_pkg.sv
// Shared constants and types for the dual-channel register bank.
// Assumes a 3-bit host address space.
package drb_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_DLO  = 3'd0;  // divisor low (enable = 1)
    localparam logic [ADDR_W-1:0] A_DHI  = 3'd1;  // divisor high (enable = 1)
    localparam logic [ADDR_W-1:0] A_ALTF = 3'd2;  // alternate function (enable = 1)
    localparam logic [ADDR_W-1:0] A_LCTL = 3'd3;  // line control, bit 7 only
    localparam logic [ADDR_W-1:0] A_SCR  = 3'd7;  // scratch byte

    typedef enum logic [1:0] {
        MF_OP2  = 2'b00,
        MF_BAUD = 2'b01,
        MF_IDLE = 2'b10,
        MF_RXR  = 2'b11
    } mf_src_e;
endpackage

// File: rtl/drb_chan_regs.sv
// One channel's registers: scratch, divisor bytes, divisor-enable and
// pin-source select. Assumes the top module supplies a write enable that
// already includes channel selection and broadcast. The broadcast flag is
// owned by the top; this block only reports a decoded write to it.
module drb_chan_regs
    import drb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cw_q,
    output logic [DATA_W-1:0] scratch_q,
    output logic [DATA_W-1:0] dlo_q,
    output logic [DATA_W-1:0] dhi_q,
    output logic              dlab_q,
    output logic [1:0]        mf_sel_q,
    output logic              altf_hit,
    output logic [DATA_W-1:0] rd_val
);
    // Flags a write that reaches the alternate function register.
    assign altf_hit = wr_en && dlab_q && (addr == A_ALTF);

    // Register update on a write aimed at this channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '1;
            dlo_q     <= '0;
            dhi_q     <= '0;
            dlab_q    <= 1'b0;
            mf_sel_q  <= 2'b00;
        end else if (wr_en) begin
            case (addr)
                A_DLO:  if (dlab_q) dlo_q <= wdata;
                A_DHI:  if (dlab_q) dhi_q <= wdata;
                A_ALTF: if (dlab_q) mf_sel_q <= wdata[2:1];
                A_LCTL: dlab_q <= wdata[DATA_W-1];
                A_SCR:  scratch_q <= wdata;
                default: ;
            endcase
        end
    end

    // Read value for the current address, decoded by this channel's enable.
    always_comb begin
        rd_val = '0;
        case (addr)
            A_DLO:  if (dlab_q) rd_val = dlo_q;
            A_DHI:  if (dlab_q) rd_val = dhi_q;
            A_ALTF: if (dlab_q) begin
                rd_val[2:1] = mf_sel_q;
                rd_val[0]   = cw_q;
            end
            A_LCTL: rd_val[DATA_W-1] = dlab_q;
            A_SCR:  rd_val = scratch_q;
            default: rd_val = '0;
        endcase
    end
endmodule

// File: rtl/drb_baud_div.sv
// Baud divider: emits a one-cycle tick every `divisor` clocks (16x rate).
// Assumes a divisor of 0 is to be treated as 1. A new divisor takes hold
// at the next reload.
module drb_baud_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_eff;

    // Clamp a zero divisor to one.
    assign div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
    // Tick whenever the down-counter sits at zero.
    assign tick    = (cnt_q == '0);

    // Down-counter that reloads on terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= div_eff - DIV_W'(1);
        else           cnt_q <= cnt_q - DIV_W'(1);
    end
endmodule

// File: rtl/drb_mf_mux.sv
// Pin-source selector for one multifunction pin. Inputs are active high;
// the pin is active low. The reserved code parks the pin high.
module drb_mf_mux
    import drb_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       op2,
    input  logic       baud_tick,
    input  logic       rx_ready,
    output logic       pin_n
);
    // Choose and invert the selected source.
    always_comb begin
        case (mf_src_e'(sel))
            MF_OP2:  pin_n = ~op2;
            MF_BAUD: pin_n = ~baud_tick;
            MF_IDLE: pin_n = 1'b1;
            MF_RXR:  pin_n = ~rx_ready;
            default: pin_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/dual_reg_bank.sv
// Top of the dual-channel register bank. Routes host writes to one or both
// channels, owns the shared broadcast flag, muxes read data by channel
// select and builds each channel's baud divider and pin mux.
// Assumes single-cycle write strobes and combinational reads.
module dual_reg_bank
    import drb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              chan_sel,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        op2_in,
    input  logic [1:0]        rx_ready_in,
    output logic [1:0]        mf_n
);
    localparam int NCH   = 2;
    localparam int DIV_W = 2 * DATA_W;

    logic                         cw_q;
    logic [NCH-1:0]               tgt;
    logic [NCH-1:0]               altf_hit;
    logic [NCH-1:0]               dlab_q;
    logic [NCH-1:0]               tick;
    logic [NCH-1:0][DATA_W-1:0]   scratch_q;
    logic [NCH-1:0][DATA_W-1:0]   dlo_q;
    logic [NCH-1:0][DATA_W-1:0]   dhi_q;
    logic [NCH-1:0][DATA_W-1:0]   rd_val;
    logic [NCH-1:0][1:0]          mf_sel_q;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        // Target this channel when selected or when broadcasting.
        assign tgt[ch] = bus_wr && (cw_q || (chan_sel == 1'(ch)));

        drb_chan_regs #(.DATA_W(DATA_W)) regs_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (tgt[ch]),
            .addr      (bus_addr),
            .wdata     (bus_wdata),
            .cw_q      (cw_q),
            .scratch_q (scratch_q[ch]),
            .dlo_q     (dlo_q[ch]),
            .dhi_q     (dhi_q[ch]),
            .dlab_q    (dlab_q[ch]),
            .mf_sel_q  (mf_sel_q[ch]),
            .altf_hit  (altf_hit[ch]),
            .rd_val    (rd_val[ch])
        );

        drb_baud_div #(.DIV_W(DIV_W)) baud_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .divisor ({dhi_q[ch], dlo_q[ch]}),
            .tick    (tick[ch])
        );

        drb_mf_mux mux_i (
            .sel       (mf_sel_q[ch]),
            .op2       (op2_in[ch]),
            .baud_tick (tick[ch]),
            .rx_ready  (rx_ready_in[ch]),
            .pin_n     (mf_n[ch])
        );
    end

    // Shared broadcast flag, writable through either channel.
    always_ff @(posedge clk) begin
        if (!rst_n)         cw_q <= 1'b0;
        else if (|altf_hit) cw_q <= bus_wdata[0];
    end

    // Read data from the selected channel only while the read strobe is high.
    assign bus_rdata = bus_rd ? rd_val[chan_sel] : '0;
endmodule

// File: rtl/drb_checker.sv
// Property checker for dual_reg_bank, bound into every instance.
module drb_checker
    import drb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic                       bus_wr,
    input logic                       bus_rd,
    input logic                       chan_sel,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic [1:0]                 mf_n,
    input logic                       cw_q,
    input logic [1:0]                 dlab_q,
    input logic [1:0][DATA_W-1:0]     scratch_q,
    input logic [1:0][1:0]            mf_sel_q
);
    p_other_a_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !cw_q && !chan_sel && bus_addr == A_SCR) |=> $stable(scratch_q[1]));
    p_other_b_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !cw_q && chan_sel && bus_addr == A_SCR) |=> $stable(scratch_q[0]));
    p_bcast_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && cw_q && bus_addr == A_SCR) |=>
        (scratch_q[0] == $past(bus_wdata)) && (scratch_q[1] == $past(bus_wdata)));
    p_rd_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
    p_altf_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_ALTF) |-> (bus_rdata[DATA_W-1:3] == '0));
    p_lctl_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_LCTL) |->
        (bus_rdata[DATA_W-1] == (chan_sel ? dlab_q[1] : dlab_q[0])));
    p_mf_idle_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_sel_q[0] == 2'b10) |-> mf_n[0]);
    p_mf_idle_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_sel_q[1] == 2'b10) |-> mf_n[1]);
    p_no_wr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(scratch_q) && $stable(cw_q)));
endmodule

bind dual_reg_bank drb_checker #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .chan_sel  (chan_sel),
    .bus_rdata (bus_rdata),
    .mf_n      (mf_n),
    .cw_q      (cw_q),
    .dlab_q    (dlab_q),
    .scratch_q (scratch_q),
    .mf_sel_q  (mf_sel_q)
);

// File: tb/dual_reg_bank_tb_top.sv
// Bench for dual_reg_bank: seeded random traffic plus directed corners,
// compared against a behavioural model kept in the bench.
module dual_reg_bank_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_wr;
    logic       bus_rd;
    logic       chan_sel;
    logic [7:0] bus_rdata;
    logic [1:0] op2_in;
    logic [1:0] rx_ready_in;
    logic [1:0] mf_n;

    int n_chk  = 0;
    int n_fail = 0;

    // Model state.
    logic [7:0] m_scr [2];
    logic [7:0] m_dlo [2];
    logic [7:0] m_dhi [2];
    logic       m_dlab[2];
    logic [1:0] m_sel [2];
    logic       m_cw;

    always #4 clk = ~clk;

    dual_reg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .chan_sel(chan_sel),
        .bus_rdata(bus_rdata), .op2_in(op2_in), .rx_ready_in(rx_ready_in),
        .mf_n(mf_n)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input int ch, input logic [2:0] a);
        case (a)
            3'd0: return m_dlab[ch] ? m_dlo[ch] : 8'h00;
            3'd1: return m_dlab[ch] ? m_dhi[ch] : 8'h00;
            3'd2: return m_dlab[ch] ? {5'b0, m_sel[ch], m_cw} : 8'h00;
            3'd3: return {m_dlab[ch], 7'b0};
            3'd7: return m_scr[ch];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_pin(input int ch);
        case (m_sel[ch])
            2'b00: return ~op2_in[ch];
            2'b10: return 1'b1;
            2'b11: return ~rx_ready_in[ch];
            default: return 1'bx;
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_scr[c] = 8'hFF; m_dlo[c] = 0; m_dhi[c] = 0; m_dlab[c] = 0; m_sel[c] = 0;
        end
        m_cw = 0;
    endtask

    task automatic do_write(input int ch, input logic [2:0] a, input logic [7:0] d);
        logic cw_now;
        cw_now = m_cw;
        for (int t = 0; t < 2; t++) begin
            if (cw_now || t == ch) begin
                case (a)
                    3'd0: if (m_dlab[t]) m_dlo[t] = d;
                    3'd1: if (m_dlab[t]) m_dhi[t] = d;
                    3'd2: if (m_dlab[t]) begin m_sel[t] = d[2:1]; m_cw = d[0]; end
                    3'd3: m_dlab[t] = d[7];
                    3'd7: m_scr[t] = d;
                    default: ;
                endcase
            end
        end
        chan_sel = ch[0]; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input int ch, input logic [2:0] a, input string tag);
        chan_sel = ch[0]; bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(tag, {8'h0, bus_rdata}, {8'h0, exp_read(ch, a)});
        bus_rd = 1'b0;
        #1;
        chk("R5 idle read zero", {8'h0, bus_rdata}, 16'h0);
        @(negedge clk);
    endtask

    task automatic check_pins(input string tag);
        #1;
        for (int c = 0; c < 2; c++)
            if (m_sel[c] != 2'b01) chk(tag, {15'h0, mf_n[c]}, {15'h0, exp_pin(c)});
    endtask

    // Measure the distance between the 2nd and 3rd low pulses on a pin.
    task automatic baud_period(input int ch, input int exp_p, input string tag);
        int seen = 0;
        int p2 = 0;
        int p3 = 0;
        for (int k = 0; k < 2000 && seen < 3; k++) begin
            @(negedge clk); #1;
            if (mf_n[ch] == 1'b0) begin
                seen++;
                if (seen == 2) p2 = k;
                if (seen == 3) p3 = k;
            end
        end
        chk(tag, 16'(p3 - p2), 16'(exp_p));
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 0; bus_addr = 0; bus_wdata = 0; bus_wr = 0; bus_rd = 0; chan_sel = 0;
        op2_in = 2'b01; rx_ready_in = 2'b00;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state.
        do_read(0, 3'd7, "R1 scratch A reset");
        do_read(1, 3'd7, "R1 scratch B reset");
        do_read(0, 3'd3, "R1 enable A reset");
        check_pins("R1 pins follow op2 at reset");

        // R7 and R2: scratch in A only.
        do_write(0, 3'd7, 8'h3C);
        do_read(0, 3'd7, "R7 scratch A readback");
        do_read(1, 3'd7, "R2 scratch B untouched");

        // R4: set broadcast through B, read flag through A.
        do_write(1, 3'd3, 8'h80);
        do_write(1, 3'd2, 8'hF9);   // sel 00, flag 1, reserved bits set
        do_write(0, 3'd3, 8'h80);
        do_read(0, 3'd2, "R4 flag visible via A, R6 reserved zero");
        do_read(1, 3'd2, "R6 reserved bits read zero");

        // R3 and R5: broadcast scratch, reads still by select.
        do_write(0, 3'd7, 8'hA5);
        do_read(1, 3'd7, "R3 broadcast reached B");
        do_read(0, 3'd7, "R5 read A under broadcast");

        // R8: split enables during broadcast.
        do_write(0, 3'd3, 8'h00);   // broadcast: both enables now 0
        do_write(1, 3'd3, 8'h00);
        m_cw = m_cw;                // broadcast still on
        // Turn A enable on alone: need broadcast off briefly.
        do_write(0, 3'd3, 8'h80);   // broadcast sets both to 1
        do_write(0, 3'd2, 8'h00);   // clear flag via A (R4)
        do_read(1, 3'd2, "R4 flag cleared via A");
        do_write(1, 3'd3, 8'h00);   // B enable off
        do_write(0, 3'd2, 8'h01);   // flag on again via A
        do_write(1, 3'd0, 8'h5A);   // broadcast: A stores, B ignores
        do_read(0, 3'd0, "R8 A stored divisor low");
        do_write(0, 3'd2, 8'h00);   // flag off
        do_write(1, 3'd3, 8'h80);
        do_read(1, 3'd0, "R8 B ignored divisor low");
        do_write(1, 3'd3, 8'h00);
        do_read(1, 3'd0, "R8 disabled address reads zero");

        // R9: pin sources on channel B.
        do_write(1, 3'd3, 8'h80);
        do_write(1, 3'd2, 8'h06);   // sel 11
        rx_ready_in = 2'b10; check_pins("R9 receive-ready source");
        rx_ready_in = 2'b00; check_pins("R9 receive-ready low");
        do_write(1, 3'd2, 8'h04);   // sel 10
        op2_in = 2'b11; check_pins("R9 reserved code idle high");

        // R10: baud clock on channel A.
        do_write(0, 3'd0, 8'h05);
        do_write(0, 3'd1, 8'h00);
        do_write(0, 3'd2, 8'h02);   // sel 01
        baud_period(0, 5, "R10 divisor 5");
        do_write(0, 3'd0, 8'h00);
        baud_period(0, 1, "R10 divisor 0 acts as 1");
        do_write(0, 3'd0, 8'h03);
        do_write(0, 3'd1, 8'h01);
        baud_period(0, 259, "R10 divisor 259");

        // R11: reads follow address combinationally.
        chan_sel = 0; bus_rd = 1; bus_addr = 3'd7; #1;
        chk("R11 combinational read scratch", {8'h0, bus_rdata}, {8'h0, m_scr[0]});
        bus_addr = 3'd3; #1;
        chk("R11 combinational read enable", {8'h0, bus_rdata}, {8'h0, exp_read(0, 3'd3)});
        bus_rd = 0;
        @(negedge clk);

        // Random traffic across all registers.
        for (int i = 0; i < 600; i++) begin
            int ch;
            int pick;
            logic [2:0] a;
            ch = int'($urandom % 2);
            pick = int'($urandom % 6);
            case (pick)
                0: a = 3'd0; 1: a = 3'd1; 2: a = 3'd2;
                3: a = 3'd3; 4: a = 3'd7; default: a = 3'd5;
            endcase
            op2_in = 2'($urandom);
            rx_ready_in = 2'($urandom);
            if ($urandom % 3 == 0) do_read(ch, a, "R2/R3/R8 random read");
            else do_write(ch, a, 8'($urandom));
            check_pins("R9 random pin");
        end
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 8; a++) do_read(c, 3'(a), "R5 final sweep");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule